// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block fronts a shared word-wide memory that two independent ports reach at the same time. Each port has an active-low select, a write strobe and two byte-lane enables, and the memory is built in. When both ports are enabled on the same word, the arbiter picks a winner and drives an active-low busy flag to the other port. The winner is the port that has held its current address longer. The loser's write is dropped, but its read is still served.

A strap selects between two modes. In master mode the block arbitrates and drives the busy outputs. In slave mode, used when several blocks are ganged side by side to build a wider word, the block does not arbitrate. Its busy outputs stay inactive and its busy inputs, fed from a master, hold off writes.

All behaviour is synchronous to one clock. Read data appears registered one cycle after the request.

Top module: `dp_contention_arbiter`

## Requirements
- R1: The memory holds 2**ADDR_W words of 16 bits (ADDR_W is 13 for an 8K-word array). A full-word write followed by a read of the same address returns the written word.
- R2: A port performs an access only when its select is low and at least one of its two lane enables is low. A write strobe with both lane enables high changes nothing.
- R3: The upper lane enable governs bits 15..8 and the lower lane enable governs bits 7..0. A write touches only the enabled lanes, and read data carries zero in any lane that is not enabled.
- R4: In master mode a port's busy output is low only in a cycle where both ports are enabled on equal addresses. It is high in any cycle where that match is absent.
- R5: On a fresh contention, the port whose address has been valid longer wins, and the other port gets busy low. A port becomes valid in the cycle it becomes enabled or changes address, whichever is later.
- R6: If both ports become valid on the same address in the same cycle, the left port wins.
- R7: Once made, a decision is kept for every following cycle in which the match persists. A new decision is taken only after the match has ended.
- R8: In master mode the losing port's write is suppressed. A losing port that reads still receives the stored data.
- R9: In slave mode both busy outputs stay high. A low busy input blocks that port's write. The held write lands in the first cycle its busy input is high again.
- R10: A port whose select is high writes nothing, and its read data register holds its previous value.
- R11: Read data is registered and appears in the cycle after the request. If the other port writes the same word in the request cycle, the newly written lanes are returned.
- R12: If both ports write the same lane of the same word in one cycle (possible only in slave mode), the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | Strap: 1 selects slave mode, 0 selects master mode |
| l_sel_n | input | 1 | Left port select, active low |
| l_wr_n | input | 1 | Left write strobe, active low (high means read) |
| l_ub_n | input | 1 | Left upper lane enable, active low |
| l_lb_n | input | 1 | Left lower lane enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_in_n | input | 1 | Left write hold-off in slave mode, active low |
| l_rdata | output | 16 | Left registered read data |
| l_busy_n | output | 1 | Left busy flag in master mode, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_ub_n | input | 1 | Right upper lane enable, active low |
| r_lb_n | input | 1 | Right lower lane enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_in_n | input | 1 | Right write hold-off in slave mode, active low |
| r_rdata | output | 16 | Right registered read data |
| r_busy_n | output | 1 | Right busy flag in master mode, active low |

## Verification
The properties assume that every control and address input is a defined level that changes only between clock edges. They also assume the strap is driven rather than left floating. The decision-holding property relies on the strap staying put for two consecutive cycles, so it says nothing about the cycle in which the mode flips. The stimulus changes all inputs on the falling edge only. It moves the strap only between scenarios or in long blocks. It steers addresses into a small window so that matches, simultaneous arrivals and late arrivals occur often.

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter #(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slave_mode,
  input  logic                l_sel_n,
  input  logic                l_wr_n,
  input  logic                l_ub_n,
  input  logic                l_lb_n,
  input  logic [ADDR_W-1:0]   l_addr,
  input  logic [2*BYTE_W-1:0] l_wdata,
  input  logic                l_busy_in_n,
  output logic [2*BYTE_W-1:0] l_rdata,
  output logic                l_busy_n,
  input  logic                r_sel_n,
  input  logic                r_wr_n,
  input  logic                r_ub_n,
  input  logic                r_lb_n,
  input  logic [ADDR_W-1:0]   r_addr,
  input  logic [2*BYTE_W-1:0] r_wdata,
  input  logic                r_busy_in_n,
  output logic [2*BYTE_W-1:0] r_rdata,
  output logic                r_busy_n
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              l_en_q, r_en_q, lock_q, win_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;

  logic l_en, r_en, match, l_fresh, r_fresh, win_now;
  logic l_lose, r_lose, l_block, r_block, l_we, r_we;
  logic [DATA_W-1:0] l_mask, r_mask, l_wm, r_wm, l_view, r_view;

  assign l_en  = !l_sel_n && !(l_ub_n && l_lb_n);
  assign r_en  = !r_sel_n && !(r_ub_n && r_lb_n);
  assign match = l_en && r_en && (l_addr == r_addr);

  assign l_fresh = l_en && (!l_en_q || (l_addr != l_addr_q));
  assign r_fresh = r_en && (!r_en_q || (r_addr != r_addr_q));

  // win_now: 1 means the right port owns the contended word
  assign win_now = lock_q ? win_q : (l_fresh && !r_fresh);

  assign l_lose = !slave_mode && match && win_now;
  assign r_lose = !slave_mode && match && !win_now;

  assign l_busy_n = !l_lose;
  assign r_busy_n = !r_lose;

  assign l_block = slave_mode ? !l_busy_in_n : l_lose;
  assign r_block = slave_mode ? !r_busy_in_n : r_lose;

  assign l_we = l_en && !l_wr_n && !l_block;
  assign r_we = r_en && !r_wr_n && !r_block;

  assign l_mask = {{BYTE_W{!l_ub_n}}, {BYTE_W{!l_lb_n}}};
  assign r_mask = {{BYTE_W{!r_ub_n}}, {BYTE_W{!r_lb_n}}};
  assign l_wm   = l_we ? l_mask : '0;
  assign r_wm   = r_we ? r_mask : '0;

  assign l_view = (l_addr == r_addr) ? ((mem[l_addr] & ~r_wm) | (r_wdata & r_wm)) : mem[l_addr];
  assign r_view = (r_addr == l_addr) ? ((mem[r_addr] & ~l_wm) | (l_wdata & l_wm)) : mem[r_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      lock_q   <= 1'b0;
      win_q    <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      lock_q   <= !slave_mode && match;
      win_q    <= win_now;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (r_wm[b*BYTE_W]) mem[r_addr][b*BYTE_W +: BYTE_W] <= r_wdata[b*BYTE_W +: BYTE_W];
      if (l_wm[b*BYTE_W]) mem[l_addr][b*BYTE_W +: BYTE_W] <= l_wdata[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en && l_wr_n) l_rdata <= l_view & l_mask;
      if (r_en && r_wr_n) r_rdata <= r_view & r_mask;
    end
  end
endmodule

// File: rtl/dp_contention_arbiter_chk.sv
module dp_contention_arbiter_chk #(
  parameter int ADDR_W = 9,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                slave_mode,
  input logic                l_sel_n,
  input logic                l_ub_n,
  input logic                l_lb_n,
  input logic [ADDR_W-1:0]   l_addr,
  input logic [2*BYTE_W-1:0] l_rdata,
  input logic                l_busy_n,
  input logic                r_sel_n,
  input logic                r_ub_n,
  input logic                r_lb_n,
  input logic [ADDR_W-1:0]   r_addr,
  input logic [2*BYTE_W-1:0] r_rdata,
  input logic                r_busy_n
);
  logic armed;
  logic both_on;

  assign both_on = !l_sel_n && !(l_ub_n && l_lb_n) && !r_sel_n && !(r_ub_n && r_lb_n)
                   && (l_addr == r_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_L_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> both_on); // R4
  AST_R_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> both_on); // R4
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n)); // R5
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n)); // R9
  AST_L_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !slave_mode && $past(!slave_mode) && both_on && $past(both_on) && $past(!l_busy_n))
    |-> !l_busy_n); // R7
  AST_R_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !slave_mode && $past(!slave_mode) && both_on && $past(both_on) && $past(!r_busy_n))
    |-> !r_busy_n); // R7
  AST_L_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    l_sel_n |=> $stable(l_rdata)); // R10
  AST_R_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    r_sel_n |=> $stable(r_rdata)); // R10
endmodule

bind dp_contention_arbiter dp_contention_arbiter_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/dp_contention_arbiter_tb.sv
`timescale 1ns/1ps
module dp_contention_arbiter_tb;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave = 1'b0;
  logic          sel_n [2];
  logic          wr_n  [2];
  logic          ub_n  [2];
  logic          lb_n  [2];
  logic          bin_n [2];
  logic [AW-1:0] addr  [2];
  logic [15:0]   wd    [2];
  logic [15:0]   l_rdata, r_rdata;
  logic          l_busy_n, r_busy_n;

  logic [15:0]   m_mem [8];
  logic [15:0]   m_rd  [2];
  logic          m_pen [2];
  logic [AW-1:0] m_paddr [2];
  logic          m_lock, m_win;
  logic          ob [2];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dp_contention_arbiter #(.ADDR_W(AW), .BYTE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave),
    .l_sel_n(sel_n[0]), .l_wr_n(wr_n[0]), .l_ub_n(ub_n[0]), .l_lb_n(lb_n[0]),
    .l_addr(addr[0]), .l_wdata(wd[0]), .l_busy_in_n(bin_n[0]),
    .l_rdata(l_rdata), .l_busy_n(l_busy_n),
    .r_sel_n(sel_n[1]), .r_wr_n(wr_n[1]), .r_ub_n(ub_n[1]), .r_lb_n(lb_n[1]),
    .r_addr(addr[1]), .r_wdata(wd[1]), .r_busy_in_n(bin_n[1]),
    .r_rdata(r_rdata), .r_busy_n(r_busy_n)
  );

  function automatic logic [15:0] fn(int a);
    return 16'h3A05 + 16'(a) * 16'h0101;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic drv(int p, bit s, bit w, bit u, bit l, int a, logic [15:0] d);
    sel_n[p] = s; wr_n[p] = w; ub_n[p] = u; lb_n[p] = l;
    addr[p] = AW'(a); wd[p] = d;
  endtask

  task automatic idle(int p);
    drv(p, 1, 1, 1, 1, 0, 16'h0);
  endtask

  task automatic cycle();
    logic en [2];
    logic fr [2];
    logic blk [2];
    logic [15:0] msk [2];
    logic [15:0] wm [2];
    logic [15:0] v;
    logic match, win;
    #2;
    for (int p = 0; p < 2; p++) begin
      en[p]  = !sel_n[p] && !(ub_n[p] && lb_n[p]);
      fr[p]  = en[p] && (!m_pen[p] || m_paddr[p] != addr[p]);
      msk[p] = {{8{!ub_n[p]}}, {8{!lb_n[p]}}};
    end
    match = en[0] && en[1] && addr[0] == addr[1];
    win   = m_lock ? m_win : (fr[0] && !fr[1]);
    ob[0] = l_busy_n;
    ob[1] = r_busy_n;
    chk("R4 left busy", 16'(ob[0]), 16'(!(!slave && match && win)));
    chk("R4 right busy", 16'(ob[1]), 16'(!(!slave && match && !win)));
    blk[0] = slave ? !bin_n[0] : (match && win);
    blk[1] = slave ? !bin_n[1] : (match && !win);
    for (int p = 0; p < 2; p++)
      wm[p] = (en[p] && !wr_n[p] && !blk[p]) ? msk[p] : 16'h0;
    for (int p = 0; p < 2; p++) begin
      if (en[p] && wr_n[p]) begin
        v = m_mem[addr[p]];
        if (addr[1-p] == addr[p]) v = (v & ~wm[1-p]) | (wd[1-p] & wm[1-p]);
        m_rd[p] = v & msk[p];
      end
    end
    m_mem[addr[1]] = (m_mem[addr[1]] & ~wm[1]) | (wd[1] & wm[1]);
    m_mem[addr[0]] = (m_mem[addr[0]] & ~wm[0]) | (wd[0] & wm[0]);
    m_lock = !slave && match;
    m_win  = win;
    for (int p = 0; p < 2; p++) begin
      m_pen[p]   = en[p];
      m_paddr[p] = addr[p];
    end
    @(posedge clk);
    @(negedge clk);
    chk("R11 left rdata", l_rdata, m_rd[0]);
    chk("R11 right rdata", r_rdata, m_rd[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p);
      bin_n[p] = 1;
      m_rd[p] = 0;
      m_pen[p] = 0;
      m_paddr[p] = 0;
    end
    for (int a = 0; a < 8; a++) m_mem[a] = 0;
    m_lock = 0;
    m_win = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset left rdata", l_rdata, 16'h0);
    chk("R11 reset right rdata", r_rdata, 16'h0);
    chk("R4 reset left busy", 16'(l_busy_n), 16'h1);
    chk("R4 reset right busy", 16'(r_busy_n), 16'h1);
    rst_n = 1;

    for (int a = 0; a < 8; a++) begin
      drv(0, 0, 0, 0, 0, a, fn(a)); idle(1); cycle();
    end
    for (int a = 0; a < 8; a++) begin
      idle(0); drv(1, 0, 1, 0, 0, a, 16'h0); cycle();
      chk("R1 word readback", r_rdata, fn(a));
    end

    drv(0, 0, 0, 0, 1, 2, 16'hABCD); idle(1); cycle();
    idle(0); drv(1, 0, 1, 1, 0, 2, 16'h0); cycle();
    chk("R3 lower lane only", r_rdata, {8'h00, fn(2) & 16'h00FF});
    drv(1, 0, 1, 0, 1, 2, 16'h0); cycle();
    chk("R3 upper lane only", r_rdata, 16'hAB00);

    drv(0, 0, 0, 1, 1, 1, 16'hFFFF); idle(1); cycle();
    idle(0); drv(1, 0, 1, 0, 0, 1, 16'h0); cycle();
    chk("R2 no lane no write", r_rdata, fn(1));

    idle(0); drv(1, 0, 1, 0, 0, 0, 16'h0); cycle();
    drv(1, 1, 0, 0, 0, 3, 16'h7777); drv(0, 0, 0, 0, 0, 0, 16'h2468); cycle();
    chk("R10 deselected rdata holds", r_rdata, fn(0));
    idle(0); drv(1, 0, 1, 0, 0, 3, 16'h0); cycle();
    chk("R10 deselected write ignored", r_rdata, fn(3));

    idle(0); idle(1); cycle();
    drv(0, 0, 1, 0, 0, 4, 16'h0); cycle();
    drv(1, 0, 0, 0, 0, 4, 16'h5555); cycle();
    chk("R5 late right loses", 16'(ob[1]), 16'h0);
    chk("R5 early left free", 16'(ob[0]), 16'h1);
    drv(1, 0, 1, 0, 0, 4, 16'h0); cycle();
    chk("R7 decision kept", 16'(ob[1]), 16'h0);
    chk("R8 loser write dropped, read served", r_rdata, fn(4));
    idle(0); cycle();
    chk("R4 busy clears without match", 16'(ob[1]), 16'h1);

    idle(0); idle(1); cycle();
    drv(0, 0, 1, 0, 0, 6, 16'h0); drv(1, 0, 1, 0, 0, 6, 16'h0); cycle();
    chk("R6 tie right busy", 16'(ob[1]), 16'h0);
    chk("R6 tie left free", 16'(ob[0]), 16'h1);

    idle(0); idle(1); cycle();
    drv(1, 0, 1, 0, 0, 7, 16'h0); cycle();
    drv(0, 0, 1, 0, 0, 7, 16'h0); cycle();
    chk("R5 late left loses", 16'(ob[0]), 16'h0);

    idle(0); idle(1); cycle();
    drv(0, 0, 0, 0, 0, 5, 16'h1234); drv(1, 0, 1, 0, 0, 5, 16'h0); cycle();
    chk("R11 forwarded write", r_rdata, 16'h1234);
    chk("R8 reader flagged", 16'(ob[1]), 16'h0);

    slave = 1;
    idle(0); idle(1); cycle();
    drv(0, 0, 0, 0, 0, 3, 16'h0F0F); bin_n[0] = 0; drv(1, 0, 1, 0, 0, 3, 16'h0); cycle();
    chk("R9 slave left busy high", 16'(ob[0]), 16'h1);
    chk("R9 slave right busy high", 16'(ob[1]), 16'h1);
    chk("R9 held write blocked", r_rdata, fn(3));
    bin_n[0] = 1; cycle();
    chk("R9 held write lands", r_rdata, 16'h0F0F);

    drv(0, 0, 0, 0, 0, 1, 16'hAAAA); drv(1, 0, 0, 0, 0, 1, 16'h5555); cycle();
    idle(0); drv(1, 0, 1, 0, 0, 1, 16'h0); cycle();
    chk("R12 left data kept", r_rdata, 16'hAAAA);
    slave = 0;

    for (int i = 0; i < 3000; i++) begin
      if (i % 600 == 0) slave = ~slave;
      for (int p = 0; p < 2; p++) begin
        int r;
        r = $urandom;
        drv(p, (r % 5) == 0, r[3], r[4] & r[5], r[6], r[9:8], 16'($urandom));
        bin_n[p] = (r[13:11] != 0);
      end
      cycle();
    end

    finish_run();
  end
endmodule